// File: doc/BRIEF.md
# Ancillary Packet ID Pair Matcher

The block monitors a stream of 10-bit video words that never pauses. A companion valid bit marks the words that count. It looks for the three-word ancillary flag: one 0x000 word followed by two 0x3FF words. The next valid word after the flag is the primary identifier. The valid word after that is the secondary identifier. Both are checked against a pair table that software or a neighbouring block loads.

The primary word is compared in parallel with every entry of the primary table. If more than one entry hits, the lowest index is kept. The secondary word must equal the secondary-table entry at that same index. The work is split over registered stages, so one word is taken every clock. The block exerts no back-pressure and runs no iterative search.

The stream and its valid bit leave through a fixed-depth delay line. The match pulse and the winning index come out beside the delayed secondary word that completed the decision. Checksum, payload capture and raster timing belong to other blocks.

Top module: `anc_id_matcher`

## Requirements
- R1: The flag is detected only over valid words. The sequence 0x000, 0x3FF, 0x3FF arms detection. A 0x000 seen while partly armed restarts the flag, so 0x000 0x000 0x3FF 0x3FF is accepted. The next valid word is treated as the primary ID and the valid word after it as the secondary ID.
- R2: The primary ID is compared against all N_ENTRIES primary-table entries. When several entries are equal to it, the lowest index is selected.
- R3: A match is reported only if the secondary word equals the secondary-table entry at the selected index. Entries at other indices never produce a match.
- R4: If the primary ID equals no entry, detection goes back to idle. The word after the rejected ID is examined as a possible flag start.
- R5: Words with valid_i low do not advance or reset detection and cannot start or complete a match.
- R6: word_o and valid_o reproduce word_i and valid_i exactly LAT cycles later. match_o pulses for one cycle together with the delayed secondary word of a matching packet.
- R7: idx_o carries the selected index while match_o is high and is zero otherwise.
- R8: Each table has its own write port (strobe, address, 10-bit data) and stores one entry per clock. A comparison made in the same cycle as a write to the entry it reads uses the entry's previous value.
- R9: rst_ni (asynchronous, active low) clears detection, valid_o, match_o and idx_o. It does not alter table contents.
- R10: A word is accepted every clock. A new flag may begin on the word right after a secondary ID, so back-to-back packets each produce their own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Qualifies word_i |
| word_i | input | 10 | Incoming stream word |
| did_we_i | input | 1 | Primary table write strobe |
| did_waddr_i | input | AW | Primary table write index |
| did_wdata_i | input | 10 | Primary table write value |
| sdid_we_i | input | 1 | Secondary table write strobe |
| sdid_waddr_i | input | AW | Secondary table write index |
| sdid_wdata_i | input | 10 | Secondary table write value |
| valid_o | output | 1 | valid_i delayed by LAT cycles |
| word_o | output | 10 | word_i delayed by LAT cycles |
| match_o | output | 1 | Matching packet, aligned with its delayed secondary word |
| idx_o | output | IW | Matched table index, zero when no match |

## Verification
A table write can land on the same clock as the comparison that reads the entry being written. The bench provokes this in two ways. It rewrites the paired secondary entry on the clock the secondary word arrives, and it rewrites the primary entry on the clock the primary word arrives. In both cases the result must reflect the old contents, and the following packets must reflect the new ones. The end of one packet and the start of the next also coincide in back-to-back packets and in a long pseudo-random run. That run mixes flag words, identifiers, idle gaps and table writes. A behavioural model judges every cycle.

// File: rtl/anc_match_pkg.sv
package anc_match_pkg;
  localparam int WORD_W = 10;
  localparam logic [WORD_W-1:0] FLAG_LO = 10'h000;
  localparam logic [WORD_W-1:0] FLAG_HI = 10'h3FF;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [2:0] {
    HS_IDLE,
    HS_FLAG1,
    HS_FLAG2,
    HS_DID,
    HS_SDID
  } hdr_state_t;
endpackage

// File: rtl/anc_id_table.sv
module anc_id_table
  import anc_match_pkg::*;
#(
  parameter int N  = 4,
  parameter int AW = 2
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  word_t         wdata_i,
  output word_t         tab_o [N]
);
  word_t tab_q [N];

  // no reset: contents survive rst_ni
  always_ff @(posedge clk_i) begin
    if (we_i && (int'(waddr_i) < N)) tab_q[waddr_i] <= wdata_i;
  end

  assign tab_o = tab_q;
endmodule

// File: rtl/anc_hdr_fsm.sv
module anc_hdr_fsm
  import anc_match_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  word_t      word_i,
  input  logic       did_hit_i,
  output hdr_state_t state_o,
  output logic       did_slot_o,
  output logic       sdid_slot_o
);
  hdr_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (valid_i) begin
      unique case (state_q)
        HS_IDLE:  state_d = (word_i == FLAG_LO) ? HS_FLAG1 : HS_IDLE;
        HS_FLAG1: state_d = (word_i == FLAG_HI) ? HS_FLAG2 :
                            (word_i == FLAG_LO) ? HS_FLAG1 : HS_IDLE;
        HS_FLAG2: state_d = (word_i == FLAG_HI) ? HS_DID :
                            (word_i == FLAG_LO) ? HS_FLAG1 : HS_IDLE;
        HS_DID:   state_d = did_hit_i ? HS_SDID : HS_IDLE;
        HS_SDID:  state_d = HS_IDLE;
        default:  state_d = HS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= HS_IDLE;
    else         state_q <= state_d;
  end

  assign state_o     = state_q;
  assign did_slot_o  = valid_i && (state_q == HS_DID);
  assign sdid_slot_o = valid_i && (state_q == HS_SDID);
endmodule

// File: rtl/anc_pair_match.sv
module anc_pair_match
  import anc_match_pkg::*;
#(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  word_t         word_i,
  input  logic          did_slot_i,
  input  logic          sdid_slot_i,
  input  word_t         did_tab_i  [N],
  input  word_t         sdid_tab_i [N],
  output logic          any_hit_o,
  output logic          match_o,
  output logic [IW-1:0] idx_o
);
  logic [N-1:0]  hit;
  logic [IW-1:0] sel, sel_q;
  logic          match_q;
  logic [IW-1:0] idx_q;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit[g] = (word_i == did_tab_i[g]);
  end

  assign any_hit_o = |hit;

  // lowest index wins
  always_comb begin
    sel = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) sel = IW'(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= '0;
      match_q <= 1'b0;
      idx_q   <= '0;
    end else begin
      if (did_slot_i) sel_q <= sel;
      if (sdid_slot_i && (word_i == sdid_tab_i[sel_q])) begin
        match_q <= 1'b1;
        idx_q   <= sel_q;
      end else begin
        match_q <= 1'b0;
        idx_q   <= '0;
      end
    end
  end

  assign match_o = match_q;
  assign idx_o   = idx_q;
endmodule

// File: rtl/anc_delay_line.sv
module anc_delay_line #(
  parameter int W     = 1,
  parameter int DEPTH = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (DEPTH == 0) begin : g_wire
    assign q_o = d_i;
  end else begin : g_sr
    logic [W-1:0] sr_q [DEPTH];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int k = 0; k < DEPTH; k++) sr_q[k] <= '0;
      end else begin
        sr_q[0] <= d_i;
        for (int k = 1; k < DEPTH; k++) sr_q[k] <= sr_q[k-1];
      end
    end
    assign q_o = sr_q[DEPTH-1];
  end
endmodule

// File: rtl/anc_id_matcher.sv
module anc_id_matcher
  import anc_match_pkg::*;
#(
  parameter int N_ENTRIES = 4,
  parameter int LAT       = 4,
  localparam int AW = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
  localparam int IW = AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [9:0]    word_i,
  input  logic          did_we_i,
  input  logic [AW-1:0] did_waddr_i,
  input  logic [9:0]    did_wdata_i,
  input  logic          sdid_we_i,
  input  logic [AW-1:0] sdid_waddr_i,
  input  logic [9:0]    sdid_wdata_i,
  output logic          valid_o,
  output logic [9:0]    word_o,
  output logic          match_o,
  output logic [IW-1:0] idx_o
);
  localparam int RES_DEPTH = (LAT > 1) ? LAT - 1 : 0;

  word_t      did_tab  [N_ENTRIES];
  word_t      sdid_tab [N_ENTRIES];
  hdr_state_t hdr_state;
  logic       did_slot, sdid_slot, any_hit;
  logic       match_s;
  logic [IW-1:0] idx_s;

  anc_id_table #(.N(N_ENTRIES), .AW(AW)) u_did_tab (
    .clk_i(clk_i), .we_i(did_we_i), .waddr_i(did_waddr_i),
    .wdata_i(did_wdata_i), .tab_o(did_tab)
  );

  anc_id_table #(.N(N_ENTRIES), .AW(AW)) u_sdid_tab (
    .clk_i(clk_i), .we_i(sdid_we_i), .waddr_i(sdid_waddr_i),
    .wdata_i(sdid_wdata_i), .tab_o(sdid_tab)
  );

  anc_hdr_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .word_i(word_i),
    .did_hit_i(any_hit), .state_o(hdr_state),
    .did_slot_o(did_slot), .sdid_slot_o(sdid_slot)
  );

  anc_pair_match #(.N(N_ENTRIES), .IW(IW)) u_match (
    .clk_i(clk_i), .rst_ni(rst_ni), .word_i(word_i),
    .did_slot_i(did_slot), .sdid_slot_i(sdid_slot),
    .did_tab_i(did_tab), .sdid_tab_i(sdid_tab),
    .any_hit_o(any_hit), .match_o(match_s), .idx_o(idx_s)
  );

  anc_delay_line #(.W(1 + WORD_W), .DEPTH(LAT)) u_stream_dly (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .d_i({valid_i, word_i}), .q_o({valid_o, word_o})
  );

  // match stage already holds one register
  anc_delay_line #(.W(1 + IW), .DEPTH(RES_DEPTH)) u_res_dly (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .d_i({match_s, idx_s}), .q_o({match_o, idx_o})
  );
endmodule

// File: rtl/anc_id_matcher_chk.sv
module anc_id_matcher_chk
  import anc_match_pkg::*;
#(
  parameter int IW = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic          valid_o,
  input logic          match_o,
  input logic [IW-1:0] idx_o,
  input hdr_state_t    state_i
);
  // R7
  idx_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !match_o |-> (idx_o == '0));

  // R6
  match_on_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> valid_o);

  // R5
  idle_word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(state_i));

  // R1
  sdid_follows_did_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == HS_SDID) |-> ($past(state_i) == HS_DID || $past(state_i) == HS_SDID));

  // R10
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |=> !match_o);
endmodule

bind anc_id_matcher anc_id_matcher_chk #(.IW(IW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .valid_o(valid_o),
  .match_o(match_o), .idx_o(idx_o), .state_i(hdr_state)
);

// File: tb/tb_anc_id_matcher.sv
module tb_anc_id_matcher;
  localparam int N   = 4;
  localparam int LAT = 4;
  localparam int AW  = 2;

  typedef struct packed {
    logic       v;
    logic [9:0] w;
    logic       m;
    logic [1:0] idx;
  } exp_t;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic [9:0] word_i = '0;
  logic did_we_i = 1'b0, sdid_we_i = 1'b0;
  logic [AW-1:0] did_waddr_i = '0, sdid_waddr_i = '0;
  logic [9:0] did_wdata_i = '0, sdid_wdata_i = '0;
  logic valid_o, match_o;
  logic [9:0] word_o;
  logic [1:0] idx_o;

  int vectors = 0, fails = 0, cycles = 0;
  int mdid [N];
  int msdid[N];
  int ms = 0, msel = 0;
  exp_t q[$];
  bit done = 0;

  always #5 clk_i = ~clk_i;

  anc_id_matcher #(.N_ENTRIES(N), .LAT(LAT)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .word_i(word_i),
    .did_we_i(did_we_i), .did_waddr_i(did_waddr_i), .did_wdata_i(did_wdata_i),
    .sdid_we_i(sdid_we_i), .sdid_waddr_i(sdid_waddr_i), .sdid_wdata_i(sdid_wdata_i),
    .valid_o(valid_o), .word_o(word_o), .match_o(match_o), .idx_o(idx_o)
  );

  task automatic step_w(input logic v, input logic [9:0] w,
                        input logic dwe, input int da, input int dd,
                        input logic swe, input int sa, input int sd,
                        input string tag);
    exp_t e;
    int found;
    valid_i = v; word_i = w;
    did_we_i = dwe; did_waddr_i = AW'(da); did_wdata_i = 10'(dd);
    sdid_we_i = swe; sdid_waddr_i = AW'(sa); sdid_wdata_i = 10'(sd);
    e = '0; e.v = v; e.w = w;
    if (v) begin
      case (ms)
        0: ms = (w == 10'h000) ? 1 : 0;
        1: ms = (w == 10'h3FF) ? 2 : ((w == 10'h000) ? 1 : 0);
        2: ms = (w == 10'h3FF) ? 3 : ((w == 10'h000) ? 1 : 0);
        3: begin
          found = -1;
          for (int k = 0; k < N; k++) if (found < 0 && mdid[k] == int'(w)) found = k;
          if (found >= 0) begin msel = found; ms = 4; end else ms = 0;
        end
        default: begin
          if (int'(w) == msdid[msel]) begin e.m = 1'b1; e.idx = 2'(msel); end
          ms = 0;
        end
      endcase
    end
    if (dwe && da < N) mdid[da] = dd;
    if (swe && sa < N) msdid[sa] = sd;
    q.push_back(e);
    @(posedge clk_i);
    @(negedge clk_i);
    vectors++;
    if (q.size() == LAT) begin
      e = q.pop_front();
      if (valid_o !== e.v || (e.v && word_o !== e.w) ||
          match_o !== e.m || idx_o !== e.idx) begin
        fails++;
        $display("FAIL %s: got v=%b w=%h m=%b idx=%0d exp v=%b w=%h m=%b idx=%0d",
                 tag, valid_o, word_o, match_o, idx_o, e.v, e.w, e.m, e.idx);
      end
    end else if (valid_o !== 1'b0 || match_o !== 1'b0) begin
      fails++;
      $display("FAIL %s: got v=%b m=%b during fill exp v=0 m=0", tag, valid_o, match_o);
    end
  endtask

  task automatic step(input logic v, input logic [9:0] w, input string tag);
    step_w(v, w, 1'b0, 0, 0, 1'b0, 0, 0, tag);
  endtask

  task automatic pkt(input logic [9:0] d, input logic [9:0] s, input string tag);
    step(1, 10'h000, tag); step(1, 10'h3FF, tag); step(1, 10'h3FF, tag);
    step(1, d, tag); step(1, s, tag);
  endtask

  task automatic flush(input string tag);
    for (int k = 0; k < LAT + 1; k++) step(0, 10'h155, tag);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; valid_i = 1'b0;
    #1;
    vectors++;
    if (valid_o !== 1'b0 || match_o !== 1'b0 || idx_o !== 2'd0) begin
      fails++;
      $display("FAIL R9: got v=%b m=%b idx=%0d exp 0 0 0", valid_o, match_o, idx_o);
    end
    q.delete(); ms = 0;
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    while (!done) begin
      @(posedge clk_i);
      cycles++;
      if (cycles > 100000) begin
        fails++;
        $display("FAIL R10 watchdog: got no end, exp finish before %0d cycles", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
      end
    end
  end

  initial begin
    int r;
    int wset [8];
    wset = '{10'h000, 10'h3FF, 10'h3FF, 10'h101, 10'h205, 10'h050, 10'h022, 10'h1FF};
    @(negedge clk_i);
    do_reset();  // R9 reset state

    // R8 table load through both ports, valid low
    step_w(0, 0, 1, 0, 'h101, 1, 0, 'h050, "R8");
    step_w(0, 0, 1, 1, 'h205, 1, 1, 'h022, "R8");
    step_w(0, 0, 1, 2, 'h101, 1, 2, 'h060, "R8");
    step_w(0, 0, 1, 3, 'h1FF, 1, 3, 'h0AA, "R8");

    pkt(10'h101, 10'h050, "R2");            // two hits, index 0 wins
    pkt(10'h101, 10'h060, "R3");            // entry 2 pair ignored
    pkt(10'h205, 10'h022, "R6");
    pkt(10'h205, 10'h050, "R3");            // wrong secondary
    flush("R6");

    // R4 rejected ID then immediate new flag
    step(1, 10'h000, "R4"); step(1, 10'h3FF, "R4"); step(1, 10'h3FF, "R4");
    step(1, 10'h333, "R4");
    pkt(10'h1FF, 10'h0AA, "R4");

    // R1 doubled flag start and restart from partial flag
    step(1, 10'h000, "R1");
    pkt(10'h205, 10'h022, "R1");
    step(1, 10'h000, "R1"); step(1, 10'h3FF, "R1");
    pkt(10'h1FF, 10'h0AA, "R1");
    flush("R1");

    // R5 invalid words with flag-like values inside a packet
    step(1, 10'h000, "R5"); step(0, 10'h123, "R5"); step(1, 10'h3FF, "R5");
    step(0, 10'h000, "R5"); step(0, 10'h000, "R5"); step(1, 10'h3FF, "R5");
    step(0, 10'h205, "R5"); step(1, 10'h101, "R5"); step(0, 10'h022, "R5");
    step(1, 10'h050, "R5");
    flush("R5");

    // R10 back-to-back packets
    pkt(10'h101, 10'h050, "R10");
    pkt(10'h205, 10'h022, "R10");
    pkt(10'h1FF, 10'h0AA, "R10");
    flush("R10");

    // R8 writes coinciding with the compares that read them
    step(1, 10'h000, "R8"); step(1, 10'h3FF, "R8"); step(1, 10'h3FF, "R8");
    step_w(1, 10'h205, 1, 1, 'h206, 0, 0, 0, "R8");
    step_w(1, 10'h022, 0, 0, 0, 1, 1, 'h023, "R8");
    pkt(10'h206, 10'h023, "R8");
    pkt(10'h206, 10'h022, "R8");
    pkt(10'h205, 10'h023, "R8");
    flush("R8");

    // R9 reset mid-packet, tables retained
    step(1, 10'h000, "R9"); step(1, 10'h3FF, "R9");
    do_reset();
    step(1, 10'h3FF, "R9"); step(1, 10'h1FF, "R9"); step(1, 10'h0AA, "R9");
    pkt(10'h1FF, 10'h0AA, "R9");
    flush("R9");

    // R2/R3 pseudo-random mix with gaps and table writes
    r = 32'h1234_5678;
    for (int n = 0; n < 3000; n++) begin
      logic wv, dw, sw;
      r = r ^ (r << 13); r = r ^ (r >>> 17); r = r ^ (r << 5);
      wv = ((r >> 5) & 3) != 0;
      dw = ((r >> 9) & 63) == 0;
      sw = ((r >> 15) & 63) == 0;
      step_w(wv, 10'(wset[r & 7]), dw, (r >> 20) & 3, wset[(r >> 22) & 7],
             sw, (r >> 24) & 3, wset[(r >> 26) & 7], "R2/R3");
    end
    flush("R6");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule